// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filtering

This block receives asynchronous serial frames on a single line. A sample-clock enable sets the sampling rate, at eight samples per bit. The receiver finds the falling edge of a start bit and checks that the start bit is real. It then decides each bit by a two-of-three vote around the middle of the bit and assembles the data bits, an optional address bit, an optional parity bit and one or two stop bits. A finished frame is placed in a holding register, and the host collects it with a read strobe.

The block targets multi-drop links in which one line serves several listeners. The host can put the receiver to sleep. While it sleeps, only frames that the receiver recognises as addresses reach the holding register. An address is recognised in one of two ways, chosen by a mode input: a long run of idle line before the frame, or an extra address bit carried inside the frame. Each accepted frame also reports parity, framing, overrun and break conditions.

Top module: `ovs_rx_top`

## Requirements
- R1: Each bit spans 8 pulses of `samp_en`, and the pulse that detects a start bit counts as sample 1. The bit value is the two-of-three majority of samples 4, 5 and 6. Samples 1–3, 7 and 8 have no effect on the value.
- R2: A low sample while hunting starts a frame. If the vote on the start bit is 1, the receiver drops the frame and produces nothing, then resumes hunting.
- R3: `data_len` holds the number of data bits minus one (0 gives 1 bit, 7 gives 8 bits). Data arrives LSB first and lands in `rx_data[0]` upward. Bits at and above the data length read 0.
- R4: When `par_en`=1, a parity bit follows the data bits and the address bit. The parity covers the data bits, the address bit (when `addr_mode`=1) and the parity bit itself. The total count of ones must be even when `par_odd`=0 and odd when `par_odd`=1, and a mismatch sets `err_parity`.
- R5: `err_frame` is the inverse of the first stop bit. The second stop bit (`two_stop`=1) is received but never checked.
- R6: `err_break` is set when every bit from the start bit through the first stop bit votes 0. Such a frame also sets `err_frame`.
- R7: `err_overrun` is set when a frame is accepted while `rx_ready` is still 1 and no read is happening in that cycle. The new data replaces the old.
- R8: A pulse on `rd_stb` clears `rx_ready`, `wake_flag` and `err_overrun`. If a frame is accepted in the same cycle, the new frame wins.
- R9: With `addr_mode`=0, a frame is an address if, just before its start bit was detected, the receiver had seen 80 or more consecutive high samples while hunting. Hunting resumes right after the vote on the last stop bit.
- R10: With `addr_mode`=1, the bit that follows the data bits is the address bit, and a 1 there marks an address frame. The length of the idle gap before the frame has no effect.
- R11: While `sleep`=1, a non-address frame changes none of `rx_data`, `rx_ready`, `wake_flag`, `addr_flag` or the error flags.
- R12: Every accepted frame loads `addr_flag` and `wake_flag` with whether that frame is an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Serial receive line, idle high |
| samp_en | input | 1 | Sample-clock enable, 8 pulses per bit |
| data_len | input | 3 | Data bits minus one |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| two_stop | input | 1 | Two stop bits |
| addr_mode | input | 1 | 0 marks addresses by idle gap, 1 by address bit |
| sleep | input | 1 | Pass only address frames |
| rd_stb | input | 1 | Host read of the data register |
| rx_data | output | 8 | Received data, zero-extended |
| rx_ready | output | 1 | Unread frame present |
| wake_flag | output | 1 | Last accepted frame was an address, not yet read |
| addr_flag | output | 1 | Last accepted frame was an address |
| err_parity | output | 1 | Parity mismatch in last accepted frame |
| err_overrun | output | 1 | Accepted frame overwrote unread data |
| err_frame | output | 1 | First stop bit was low |
| err_break | output | 1 | Whole frame through stop was low |

## Verification
The bench places line changes on individual sample slots. It corrupts samples outside the 4–6 window, then one sample inside it, then two. A receiver that voted at the wrong position, or decided a bit from a single sample, would return wrong data. It also sends a start pulse too short to reach the vote point, which a receiver without start validation would turn into a frame of garbage. In idle-gap mode it tests gaps on both sides of the 80-sample threshold. An off-by-one in the gap counter, or counting that begins at the wrong moment, would flip whether the frame is accepted. Further cases check that a low second stop bit raises no framing error. They also check that a frame with bad framing received during sleep leaves every flag untouched, and that an address bit of 0 after a long gap is still filtered in address-bit mode.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       abit;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rx_frame_t;

  // two-of-three majority
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // 1 when the ones count disagrees with the selected parity sense
  function automatic logic par_bad(input logic [7:0] d, input logic ab,
                                   input logic pb, input logic odd);
    return (^d) ^ ab ^ pb ^ odd;
  endfunction

endpackage

// File: rtl/ovs_rx_sampler.sv
module ovs_rx_sampler #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic line_in,
  input  logic halt,
  output logic busy,
  output logic bit_vld,
  output logic bit_val
);
  import ovs_rx_pkg::*;

  localparam int PW  = $clog2(OSR + 1);
  localparam int MID = OSR / 2 + 1;

  logic [PW-1:0] ph, ph_n;
  logic          s_lo, s_mid;

  assign ph_n = (ph == PW'(OSR)) ? PW'(1) : ph + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= '0;
      s_lo    <= 1'b0;
      s_mid   <= 1'b0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (halt) begin
        busy <= 1'b0;
      end else if (samp_en) begin
        if (!busy) begin
          if (!line_in) begin
            busy <= 1'b1;
            ph   <= PW'(1);
          end
        end else begin
          ph <= ph_n;
          if (ph_n == PW'(MID - 1)) s_lo  <= line_in;
          if (ph_n == PW'(MID))     s_mid <= line_in;
          if (ph_n == PW'(MID + 1)) begin
            bit_vld <= 1'b1;
            bit_val <= vote3(s_lo, s_mid, line_in);
          end
        end
      end
    end
  end

  // R1
  vote_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> (busy && ph == PW'(MID + 1)));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!line_in && samp_en));

endmodule

// File: rtl/ovs_rx_idle.sv
module ovs_rx_idle #(
  parameter int OSR       = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_en,
  input  logic line_in,
  input  logic busy,
  output logic gap_seen
);
  localparam int LIM = OSR * IDLE_BITS;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      gap_seen <= 1'b0;
    end else if (samp_en && !busy) begin
      if (line_in) begin
        if (cnt != CW'(LIM)) cnt <= cnt + CW'(1);
      end else begin
        gap_seen <= (cnt == CW'(LIM));
        cnt      <= '0;
      end
    end
  end

  // R9
  gap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && !busy && line_in) |=> $stable(gap_seen));

endmodule

// File: rtl/ovs_rx_frame.sv
module ovs_rx_frame (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_vld,
  input  logic                   bit_val,
  input  logic [2:0]             data_len,
  input  logic                   par_en,
  input  logic                   par_odd,
  input  logic                   two_stop,
  input  logic                   addr_mode,
  output logic                   halt,
  output logic                   done,
  output ovs_rx_pkg::rx_frame_t  frm
);
  import ovs_rx_pkg::*;

  logic [3:0] idx, nlen, p_a, p_p, p_s, p_l;
  logic [7:0] shr, n_shr;
  logic       abit, pbit, ferr, allz;
  logic       n_abit, n_pbit, n_ferr, n_allz;

  assign nlen = {1'b0, data_len} + 4'd1;
  assign p_a  = nlen + 4'd1;
  assign p_p  = p_a + {3'b0, addr_mode};
  assign p_s  = p_p + {3'b0, par_en};
  assign p_l  = p_s + {3'b0, two_stop};

  always_comb begin
    n_shr  = shr;
    n_abit = abit;
    n_pbit = pbit;
    n_ferr = ferr;
    n_allz = allz;
    for (int i = 0; i < 8; i++)
      if (idx == 4'(i + 1) && idx < p_a) n_shr[i] = bit_val;
    if (addr_mode && idx == p_a) n_abit = bit_val;
    if (par_en && idx == p_p)    n_pbit = bit_val;
    if (idx == p_s)              n_ferr = !bit_val;
    if (idx <= p_s)              n_allz = allz & !bit_val;
  end

  assign halt = bit_vld && ((idx == 4'd0) ? bit_val : (idx == p_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      shr  <= '0;
      abit <= 1'b0;
      pbit <= 1'b0;
      ferr <= 1'b0;
      allz <= 1'b0;
      done <= 1'b0;
      frm  <= '0;
    end else begin
      done <= 1'b0;
      if (bit_vld) begin
        if (idx == 4'd0) begin
          if (!bit_val) begin
            idx  <= 4'd1;
            shr  <= '0;
            abit <= 1'b0;
            pbit <= 1'b0;
            ferr <= 1'b0;
            allz <= 1'b1;
          end
        end else if (idx == p_l) begin
          idx       <= '0;
          done      <= 1'b1;
          frm.data  <= n_shr;
          frm.abit  <= n_abit;
          frm.perr  <= par_en & par_bad(n_shr, addr_mode & n_abit, n_pbit, par_odd);
          frm.ferr  <= n_ferr;
          frm.brk   <= n_allz;
        end else begin
          idx  <= idx + 4'd1;
          shr  <= n_shr;
          abit <= n_abit;
          pbit <= n_pbit;
          ferr <= n_ferr;
          allz <= n_allz;
        end
      end
    end
  end

  // R6
  brk_implies_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frm.brk) |-> frm.ferr);

  // R3
  done_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idx == 4'd0 && $past(bit_vld)));

endmodule

// File: rtl/ovs_rx_top.sv
module ovs_rx_top #(
  parameter int OSR       = 8,
  parameter int IDLE_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       samp_en,
  input  logic [2:0] data_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       addr_mode,
  input  logic       sleep,
  input  logic       rd_stb,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       wake_flag,
  output logic       addr_flag,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_frame,
  output logic       err_break
);
  import ovs_rx_pkg::*;

  logic      busy, bit_vld, bit_val, halt, done, gap_seen;
  logic      is_addr, accept;
  rx_frame_t frm;

  ovs_rx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line_in(line_in),
    .halt(halt), .busy(busy), .bit_vld(bit_vld), .bit_val(bit_val)
  );

  ovs_rx_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .line_in(line_in),
    .busy(busy), .gap_seen(gap_seen)
  );

  ovs_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .addr_mode(addr_mode),
    .halt(halt), .done(done), .frm(frm)
  );

  assign is_addr = addr_mode ? frm.abit : gap_seen;
  assign accept  = done && (!sleep || is_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      wake_flag   <= 1'b0;
      addr_flag   <= 1'b0;
      err_parity  <= 1'b0;
      err_overrun <= 1'b0;
      err_frame   <= 1'b0;
      err_break   <= 1'b0;
    end else if (accept) begin
      rx_data     <= frm.data;
      rx_ready    <= 1'b1;
      wake_flag   <= is_addr;
      addr_flag   <= is_addr;
      err_parity  <= frm.perr;
      err_frame   <= frm.ferr;
      err_break   <= frm.brk;
      err_overrun <= rx_ready && !rd_stb;
    end else if (rd_stb) begin
      rx_ready    <= 1'b0;
      wake_flag   <= 1'b0;
      err_overrun <= 1'b0;
    end
  end

  // R11
  sleep_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sleep && !is_addr && !rd_stb) |=>
      ($stable(rx_data) && $stable(rx_ready) && $stable(err_frame) &&
       $stable(err_parity) && $stable(err_break) && $stable(addr_flag)));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !done) |=> (!rx_ready && !wake_flag && !err_overrun));

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!sleep || is_addr) && rx_ready && !rd_stb) |=> err_overrun);

  // R12
  wake_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag |-> addr_flag);

endmodule

// File: tb/sim_ovs_rx_top.sv
module sim_ovs_rx_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b1;
  logic       samp_en;
  logic [2:0] data_len;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic       addr_mode = 1'b0, sleep = 1'b0, rd_stb = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, wake_flag, addr_flag;
  logic       err_parity, err_overrun, err_frame, err_break;

  int n_chk = 0;
  int n_err = 0;
  int len_bits = 8;
  int cyc = 0;
  logic [1:0] sc = 2'd0;

  always #2 clk = ~clk;
  always @(posedge clk) begin
    sc  <= sc + 2'd1;
    cyc <= cyc + 1;
  end
  assign samp_en  = (sc == 2'd3);
  assign data_len = 3'(len_bits - 1);

  ovs_rx_top u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .samp_en(samp_en),
    .data_len(data_len), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .addr_mode(addr_mode), .sleep(sleep),
    .rd_stb(rd_stb), .rx_data(rx_data), .rx_ready(rx_ready),
    .wake_flag(wake_flag), .addr_flag(addr_flag), .err_parity(err_parity),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_break(err_break)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one sample slot: the line value seen by the next samp_en edge
  task automatic slot(input logic v);
    @(negedge clk);
    while (!samp_en) @(negedge clk);
    line_in = v;
  endtask

  // mask bit k inverts sample k+1 of this bit
  task automatic bitw(input logic v, input logic [7:0] m);
    for (int k = 0; k < 8; k++) slot(v ^ m[k]);
  endtask

  task automatic idle_bits(input int n);
    repeat (n) bitw(1'b1, 8'h00);
  endtask

  task automatic send(input logic [7:0] d, input logic ab, input logic pflip,
                      input logic st1, input logic [7:0] dmask, input logic [7:0] s2mask);
    logic p;
    p = 1'b0;
    bitw(1'b0, 8'h00);
    for (int i = 0; i < len_bits; i++) begin
      bitw(d[i], dmask);
      p = p ^ d[i];
    end
    if (addr_mode) begin
      bitw(ab, 8'h00);
      p = p ^ ab;
    end
    if (par_en) bitw(p ^ par_odd ^ pflip, 8'h00);
    bitw(st1, 8'h00);
    if (two_stop) bitw(1'b1, s2mask);
    @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset ready", rx_ready, 0);
    chk("R12 reset wake", wake_flag, 0);
    chk("R3 reset data", rx_data, 0);
    chk("R7 reset flags", {err_parity, err_overrun, err_frame, err_break}, 0);
  endtask

  task automatic t_basic();
    idle_bits(12);
    send(8'hA5, 0, 0, 1, 8'h00, 8'h00);
    chk("R3 data", rx_data, 8'hA5);
    chk("R3 ready", rx_ready, 1);
    chk("R9 long gap address", addr_flag, 1);
    chk("R12 wake on address", wake_flag, 1);
    rd();
    chk("R8 read clears", {rx_ready, wake_flag}, 0);
    idle_bits(1);
    send(8'h3C, 0, 0, 1, 8'h00, 8'h00);
    chk("R12 data frame flags", {addr_flag, wake_flag}, 0);
    chk("R3 data 2", rx_data, 8'h3C);
    rd();
  endtask

  task automatic t_len5();
    len_bits = 5;
    idle_bits(1);
    send(8'hFF, 0, 0, 1, 8'h00, 8'h00);
    chk("R3 upper bits zero", rx_data, 8'h1F);
    rd();
    len_bits = 8;
  endtask

  task automatic t_vote();
    idle_bits(1);
    send(8'h5A, 0, 0, 1, 8'b1100_0111, 8'h00);
    chk("R1 outside window ignored", rx_data, 8'h5A);
    rd();
    idle_bits(1);
    send(8'h5A, 0, 0, 1, 8'b0001_0000, 8'h00);
    chk("R1 single glitch outvoted", rx_data, 8'h5A);
    rd();
    idle_bits(1);
    send(8'h5A, 0, 0, 1, 8'b0011_0000, 8'h00);
    chk("R1 two samples decide", rx_data, 8'hA5);
    rd();
  endtask

  task automatic t_false_start();
    idle_bits(1);
    bitw(1'b0, 8'b1111_1000);
    idle_bits(12);
    chk("R2 short start rejected", rx_ready, 0);
    chk("R2 data unchanged", rx_data, 8'hA5);
    send(8'h81, 0, 0, 1, 8'h00, 8'h00);
    chk("R2 recovers", {rx_ready, rx_data}, {1'b1, 8'h81});
    rd();
  endtask

  task automatic t_parity();
    par_en = 1'b1;
    par_odd = 1'b0;
    idle_bits(1);
    send(8'h07, 0, 0, 1, 8'h00, 8'h00);
    chk("R4 even ok", err_parity, 0);
    rd(); idle_bits(1);
    send(8'h07, 0, 1, 1, 8'h00, 8'h00);
    chk("R4 even bad", err_parity, 1);
    rd(); par_odd = 1'b1; idle_bits(1);
    send(8'h07, 0, 0, 1, 8'h00, 8'h00);
    chk("R4 odd ok", err_parity, 0);
    rd(); idle_bits(1);
    send(8'h07, 0, 1, 1, 8'h00, 8'h00);
    chk("R4 odd bad", err_parity, 1);
    rd();
    addr_mode = 1'b1; par_odd = 1'b0; idle_bits(1);
    send(8'h00, 1, 0, 1, 8'h00, 8'h00);
    chk("R4 address bit covered", err_parity, 0);
    chk("R10 address bit read", addr_flag, 1);
    rd();
    addr_mode = 1'b0; par_en = 1'b0;
  endtask

  task automatic t_frame();
    idle_bits(1);
    send(8'h55, 0, 0, 0, 8'h00, 8'h00);
    chk("R5 low stop", {err_frame, err_break}, 2'b10);
    rd(); idle_bits(2);
    two_stop = 1'b1;
    send(8'h55, 0, 0, 1, 8'h00, 8'b0011_1111);
    chk("R5 second stop unchecked", {rx_ready, err_frame}, 2'b10);
    rd(); two_stop = 1'b0;
  endtask

  task automatic t_break();
    idle_bits(1);
    send(8'h00, 0, 0, 0, 8'h00, 8'h00);
    chk("R6 break", {err_break, err_frame, rx_data}, {2'b11, 8'h00});
    rd(); idle_bits(2);
  endtask

  task automatic t_overrun();
    idle_bits(1);
    send(8'h11, 0, 0, 1, 8'h00, 8'h00);
    chk("R7 no overrun first", err_overrun, 0);
    idle_bits(1);
    send(8'h22, 0, 0, 1, 8'h00, 8'h00);
    chk("R7 overrun set", {err_overrun, rx_data}, {1'b1, 8'h22});
    rd();
    chk("R8 read clears overrun", err_overrun, 0);
  endtask

  task automatic t_sleep_idle();
    sleep = 1'b1;
    addr_mode = 1'b0;
    idle_bits(1);
    send(8'h66, 0, 0, 0, 8'h00, 8'h00);
    chk("R11 error suppressed", {rx_ready, err_frame}, 0);
    chk("R11 data kept", rx_data, 8'h22);
    idle_bits(2);
    send(8'h67, 0, 0, 1, 8'h00, 8'h00);
    chk("R11 short gap ignored", rx_ready, 0);
    idle_bits(9);
    send(8'h68, 0, 0, 1, 8'h00, 8'h00);
    chk("R9 74 samples not address", rx_ready, 0);
    idle_bits(10);
    send(8'h69, 0, 0, 1, 8'h00, 8'h00);
    chk("R9 82 samples address", {rx_ready, wake_flag, addr_flag, rx_data},
        {3'b111, 8'h69});
    rd();
  endtask

  task automatic t_sleep_addr();
    addr_mode = 1'b1;
    idle_bits(12);
    send(8'h70, 0, 0, 1, 8'h00, 8'h00);
    chk("R10 long gap no effect", rx_ready, 0);
    idle_bits(1);
    send(8'h42, 1, 0, 1, 8'h00, 8'h00);
    chk("R10 address bit wakes", {rx_ready, wake_flag, addr_flag, rx_data},
        {3'b111, 8'h42});
    rd();
    sleep = 1'b0;
    idle_bits(1);
    send(8'h43, 0, 0, 1, 8'h00, 8'h00);
    chk("R12 awake data frame", {rx_ready, wake_flag, addr_flag}, 3'b100);
    rd();
    addr_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_basic();
    t_len5();
    t_vote();
    t_false_start();
    t_parity();
    t_frame();
    t_break();
    t_overrun();
    t_sleep_idle();
    t_sleep_addr();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule